// File: doc/BRIEF.md
# Triangle primitive assembler

This block turns a stream of vertices, taken one per handshake, into triangles. A triangle leaves the block as three vertex payloads with a valid strobe. The payload is an opaque vector whose width is a parameter.

Four topology codes decide how incoming vertices combine:
- In the list code, each group of three vertices forms one triangle.
- In the strip code, each new vertex pairs with the two vertices before it.
- In the fan code, each new vertex pairs with the first vertex and the previous one.
- The programmable-setup code assembles triangles exactly as the list code does.

A configuration write selects the topology, and a restart strobe drops any partial assembly. The output is registered behind a simple ready/valid handshake.

Top module: `tri_assembler`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the topology is list (code 0).
- R2: Topology code 0 (list): the 1st and 2nd vertices of a group are stored, the 3rd emits the triangle (1st, 2nd, 3rd), and the next vertex starts a new group.
- R3: Topology code 3 (programmable setup) assembles triangles exactly as code 0 does.
- R4: Topology code 1 (strip): vertex k (counted from 0 since the last clear) goes to slot k mod 2. From k = 2 on, each vertex emits (slot 0, slot 1, new vertex), using the slot contents before that vertex is written. So vertices a,b,c,d,e give (a,b,c), (c,b,d), (c,d,e).
- R5: Topology code 2 (fan): vertex 0 goes to slot 0 and every later vertex to slot 1. From k = 2 on, each vertex emits (slot 0, slot 1, new vertex). So vertices a,b,c,d give (a,b,c), (a,c,d).
- R6: A `restart` pulse clears the slot position and the strip/fan ready condition. No triangle is emitted until a full set of fresh vertices has arrived.
- R7: A `cfg_we` pulse loads the topology from `cfg_word` bits [9:8], ignores all other bits, and clears the assembly state as `restart` does.
- R8: When `restart` or `cfg_we` coincides with an accepted vertex, the clear applies first. That vertex then becomes vertex 0 under the (possibly new) topology.
- R9: A triangle appears on the outputs in the cycle after the handshake of its last vertex. It stays stable while `out_ready` is low, and `in_ready` is low for as long as a triangle waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | CW | Configuration word; topology code in bits [9:8] |
| restart | input | 1 | Clears the partial assembly |
| in_valid | input | 1 | Input vertex valid |
| in_ready | output | 1 | Block can take a vertex |
| in_vtx | input | VW | Vertex payload |
| out_valid | output | 1 | Triangle valid |
| out_ready | input | 1 | Downstream takes the triangle |
| out_v0 | output | VW | Triangle vertex from slot 0 |
| out_v1 | output | VW | Triangle vertex from slot 1 |
| out_v2 | output | VW | Triangle vertex that completed it |

## Verification
Two things can land in the same cycle: a clear, from either `restart` or a topology write, and the acceptance of a vertex. The bench drives both strobes together with `in_valid`, while a strip or a list group is half built. The reference model applies the clear first and counts the vertex as the first one of a new assembly. The next triangle must therefore appear only after two more vertices, built from that vertex. The case is judged by comparing every output with the model on every clock.

// File: rtl/tri_assembler.sv
module tri_assembler #(
  parameter int VW = 16,
  parameter int CW = 32,
  parameter int TOPO_LSB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_word,
  input  logic          restart,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VW-1:0] in_vtx,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] out_v0,
  output logic [VW-1:0] out_v1,
  output logic [VW-1:0] out_v2
);
  localparam logic [1:0] T_LIST  = 2'd0;
  localparam logic [1:0] T_STRIP = 2'd1;
  localparam logic [1:0] T_PROG  = 2'd3;

  logic [1:0]    topo, idx;
  logic          rdy;
  logic [VW-1:0] s0, s1;
  logic          unused_cfg_bits;

  assign unused_cfg_bits = ^cfg_word;

  wire       clr      = restart | cfg_we;
  wire [1:0] topo_eff = cfg_we ? cfg_word[TOPO_LSB +: 2] : topo;
  wire [1:0] idx_eff  = clr ? 2'd0 : idx;
  wire       rdy_eff  = clr ? 1'b0 : rdy;
  wire       listy    = (topo_eff == T_LIST) || (topo_eff == T_PROG);

  assign in_ready = !out_valid || out_ready;
  wire acc  = in_valid && in_ready;
  wire emit = acc && (listy ? (idx_eff == 2'd2) : rdy_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      topo      <= T_LIST;
      idx       <= 2'd0;
      rdy       <= 1'b0;
      s0        <= '0;
      s1        <= '0;
      out_valid <= 1'b0;
      out_v0    <= '0;
      out_v1    <= '0;
      out_v2    <= '0;
    end else begin
      topo <= topo_eff;
      idx  <= idx_eff;
      rdy  <= rdy_eff;
      if (acc) begin
        if (listy && idx_eff == 2'd2) begin
          idx <= 2'd0;
        end else begin
          if (idx_eff[0]) s1 <= in_vtx;
          else            s0 <= in_vtx;
          if (listy) begin
            idx <= idx_eff + 2'd1;
          end else begin
            rdy <= rdy_eff | idx_eff[0];
            idx <= (topo_eff == T_STRIP) ? {1'b0, ~idx_eff[0]} : 2'd1;
          end
        end
      end
      if (emit) begin
        out_valid <= 1'b1;
        out_v0    <= s0;
        out_v1    <= s1;
        out_v2    <= in_vtx;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module tri_assembler_chk #(
  parameter int VW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          restart,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_v0,
  input logic [VW-1:0] out_v1,
  input logic [VW-1:0] out_v2
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_v0) && $stable(out_v1) && $stable(out_v2)));

  p_stall_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !(out_valid && !out_ready)) |=> !out_valid);

  p_cfg_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(out_valid && !out_ready)) |=> !out_valid);
endmodule

bind tri_assembler tri_assembler_chk #(.VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .restart(restart),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_v0(out_v0), .out_v1(out_v1), .out_v2(out_v2)
);

// File: tb/tri_assembler_tb.sv
module tri_assembler_tb_top;
  localparam int VW = 16;
  localparam int CW = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0, restart = 0, in_valid = 0, out_ready = 1;
  logic [CW-1:0] cfg_word = '0;
  logic [VW-1:0] in_vtx = '0;
  logic in_ready, out_valid;
  logic [VW-1:0] out_v0, out_v1, out_v2;

  always #10 clk = ~clk;

  tri_assembler #(.VW(VW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .restart(restart), .in_valid(in_valid), .in_ready(in_ready), .in_vtx(in_vtx),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_v0(out_v0), .out_v1(out_v1), .out_v2(out_v2)
  );

  int errors = 0, checks = 0;
  string tag = "R1";

  int m_topo = 0;
  logic [VW-1:0] hist[$];
  bit m_ov = 0;
  logic [3*VW-1:0] m_tri = '0;
  logic [VW-1:0] vnext = 16'h0100;

  task automatic chk(bit ok, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit rs, bit cw, int tp, bit ordy);
    bit acc, exp_rdy;
    int k, e, o;
    logic [VW-1:0] d;
    d = vnext;
    in_valid = v; in_vtx = d; restart = rs; cfg_we = cw; out_ready = ordy;
    cfg_word = (32'(tp) << 8) | 32'hFFFF_FCFF & 32'h5A5A_00A5;
    #5;
    exp_rdy = !m_ov || ordy;
    chk(in_ready == exp_rdy, "in_ready", in_ready, exp_rdy);
    acc = v && exp_rdy;
    if (acc) vnext = vnext + 16'h0011;
    @(posedge clk); #1;
    in_valid = 0; restart = 0; cfg_we = 0;
    if (m_ov && ordy) m_ov = 0;
    if (cw) m_topo = tp;
    if (cw || rs) hist.delete();
    if (acc) begin
      k = hist.size();
      if (m_topo == 0 || m_topo == 3) begin
        if (k == 2) begin
          m_ov = 1; m_tri = {hist[0], hist[1], d}; hist.delete();
        end else hist.push_back(d);
      end else begin
        if (k >= 2) begin
          m_ov = 1;
          if (m_topo == 1) begin
            e = ((k - 1) % 2 == 0) ? k - 1 : k - 2;
            o = ((k - 1) % 2 == 1) ? k - 1 : k - 2;
            m_tri = {hist[e], hist[o], d};
          end else m_tri = {hist[0], hist[k-1], d};
        end
        hist.push_back(d);
      end
    end
    chk(out_valid == m_ov, "out_valid", out_valid, m_ov);
    if (m_ov) chk({out_v0, out_v1, out_v2} == m_tri, "triangle",
                  {out_v0, out_v1, out_v2}, m_tri);
  endtask

  task automatic feed(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 1);
  endtask

  task automatic setup(int tp);
    step(0, 0, 1, tp, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    tag = "R1";
    #5;
    chk(out_valid == 0, "reset out_valid", out_valid, 0);
    chk(in_ready == 1, "reset in_ready", in_ready, 1);
    @(posedge clk); #1;
    feed(3);
    tag = "R2";
    feed(2); step(0, 0, 0, 0, 1); feed(5); step(0, 0, 0, 0, 1); feed(2);
    tag = "R3";
    setup(3); feed(7);
    tag = "R4";
    setup(1); feed(7);
    tag = "R5";
    setup(2); feed(6);
    tag = "R6";
    setup(1); feed(3); step(0, 1, 0, 0, 1); feed(4);
    setup(0); feed(2); step(0, 1, 0, 0, 1); feed(3);
    tag = "R7";
    feed(1); setup(2); feed(4); setup(1); feed(1); setup(0); feed(4);
    tag = "R8";
    setup(1); feed(4); step(1, 1, 0, 0, 1); feed(3);
    feed(2); step(1, 0, 1, 2, 1); feed(3);
    setup(0); feed(1); step(1, 0, 1, 3, 1); feed(3);
    tag = "R9";
    setup(1); feed(2);
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 1); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 1); feed(3);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule